// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block sits behind a configuration port and watches a stream of 32-bit words qualified by a valid strobe. Out of reset it is hunting. In that state it throws away every word until the synchronization word `0xAA995566` arrives. The discarded words include pad words and bus-width probe patterns.

Once synchronized, it reads each word as a packet header. There are two header forms. A short header names a 5-bit register address and carries an 11-bit word count. A bulk header carries no address but a 27-bit count. It must directly follow a short header whose count is zero, and it reuses that header's address. Every payload word is passed on unchanged as a register-write strobe with its address and data, in the same cycle the word arrives. The block never stalls its source.

When the value 13 is written to register address 4, the parser drops back to hunting. A fresh synchronization word is then needed. Malformed headers raise a one-cycle error flag and are otherwise skipped.

Top module: `cfg_packet_parser`

## Requirements
- R1: While hunting (`synced` low), every word is discarded with no write and no error, until a word equal to `0xAA995566` is accepted. `synced` is high from the next cycle.
- R2: In the header state, the exact word `0x20000000` is a no-operation: no write, no error, and the state is unchanged.
- R3: A short write header has bits[31:29]=001 and bits[28:27]=10. Its address is bits[17:13] and its count is bits[10:0]. A nonzero count produces exactly that many writes, one per following accepted word. Each write carries that address and the word as data.
- R4: A short write header with count zero produces no write. It leaves the parser expecting a header, with its address armed for a bulk header that comes immediately after it.
- R5: A bulk header (bits[31:29]=010) that directly follows a zero-count short header takes its count from bits[26:0]. The following that many words are written to the armed address.
- R6: While payload words remain, every accepted word is written as data, even if it equals the sync word, a NOP or a header pattern.
- R7: The write of data 13 to address 4 is emitted and then returns the parser to hunting, even if payload words remain. Headers are then ignored until a new sync word.
- R8: In the header state, any non-NOP word whose type or opcode is not one of the two forms in R3 and R5 pulses `hdr_err` in the same cycle. It produces no write, and the next word is again read as a header.
- R9: A bulk header that does not directly follow a zero-count short header pulses `hdr_err` and is otherwise skipped. Any intervening word, including a NOP, breaks the pairing.
- R10: `wr_valid`, `wr_addr`, `wr_data` and `hdr_err` respond in the same cycle as the input word. A cycle with `in_valid` low produces no output and does not change the state or the remaining count.
- R11: A synchronous active-high reset returns the parser to hunting with the count and the armed address cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Input stream word |
| wr_valid | output | 1 | Register-write strobe for the current word |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 32 | Data of the write |
| hdr_err | output | 1 | Malformed or unpaired header in the current word |
| synced | output | 1 | High once the sync word has been seen |

## Verification
The assertions assume `in_valid` and `in_word` are stable, known values whenever they are sampled. They also assume the source never needs backpressure, so every valid word is consumed in its own cycle. The stimulus drives inputs only on the falling clock edge and holds them through the rising edge. It puts idle cycles inside payloads and between headers. Its header words are built bit by bit from the field positions in the requirements, so the bench and the design never share a decoder.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int CNT_W   = 27;

    localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;
    localparam logic [WORD_W-1:0] NOP_WORD  = 32'h20000000;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2
    } pstate_t;

    typedef enum logic [1:0] {
        HK_NOP   = 2'd0,
        HK_SHORT = 2'd1,
        HK_BULK  = 2'd2,
        HK_BAD   = 2'd3
    } hkind_t;

    typedef struct packed {
        hkind_t            kind;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
    } hdr_t;

    // Classify one header word and pull out its fields.
    function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.addr  = w[17:13];
        h.count = '0;
        if (w == NOP_WORD) begin
            h.kind = HK_NOP;
        end else if (w[31:29] == 3'b001 && w[28:27] == 2'b10) begin
            h.kind  = HK_SHORT;
            h.count = CNT_W'(w[10:0]);
        end else if (w[31:29] == 3'b010) begin
            h.kind  = HK_BULK;
            h.count = w[26:0];
        end else begin
            h.kind = HK_BAD;
        end
        return h;
    endfunction

endpackage

// File: rtl/cfgp_hdr_decode.sv
module cfgp_hdr_decode
    import cfgp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output hdr_t              hdr_o
);
    always_comb hdr_o = decode_hdr(word_i);
endmodule

// File: rtl/cfgp_word_counter.sv
module cfgp_word_counter #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (dec && cnt != '0)  cnt <= cnt - ONE;
    end

    assign last = (cnt == ONE);

    // R10: the count moves only on an accepted word
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !load && !dec |=> $stable(cnt));
endmodule

// File: rtl/cfg_packet_parser.sv
module cfg_packet_parser
    import cfgp_pkg::*;
#(
    parameter int          CMD_ADDR    = 4,
    parameter int          DESYNC_CODE = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    output logic        wr_valid,
    output logic [4:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic        hdr_err,
    output logic        synced
);
    localparam logic [ADDR_W-1:0] CMD_A   = ADDR_W'(CMD_ADDR);
    localparam logic [WORD_W-1:0] DESYNC  = WORD_W'(DESYNC_CODE);

    pstate_t            state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               bulk_ok_q;

    hdr_t               hdr;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_last;
    logic               in_hdr, in_data, desync_hit;
    logic               hdr_load, cnt_load, cnt_dec;
    logic [CNT_W-1:0]   cnt_val;

    cfgp_hdr_decode u_dec (
        .word_i (in_word),
        .hdr_o  (hdr)
    );

    assign in_hdr     = in_valid && state_q == ST_HDR;
    assign in_data    = in_valid && state_q == ST_DATA;
    assign desync_hit = in_data && addr_q == CMD_A && in_word == DESYNC;
    assign hdr_load   = in_hdr && (hdr.kind == HK_SHORT ||
                                   (hdr.kind == HK_BULK && bulk_ok_q));
    assign cnt_load   = hdr_load || desync_hit;
    assign cnt_val    = desync_hit ? '0 : hdr.count;
    assign cnt_dec    = in_data;

    cfgp_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    assign wr_valid = in_data;
    assign wr_addr  = addr_q;
    assign wr_data  = in_word;
    assign hdr_err  = in_hdr && (hdr.kind == HK_BAD ||
                                 (hdr.kind == HK_BULK && !bulk_ok_q));
    assign synced   = (state_q != ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HUNT;
            addr_q    <= '0;
            bulk_ok_q <= 1'b0;
        end else if (in_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    bulk_ok_q <= 1'b0;
                    if (in_word == SYNC_WORD) state_q <= ST_HDR;
                end
                ST_HDR: begin
                    bulk_ok_q <= 1'b0;
                    if (hdr.kind == HK_SHORT) begin
                        addr_q    <= hdr.addr;
                        bulk_ok_q <= (hdr.count == '0);
                        if (hdr.count != '0) state_q <= ST_DATA;
                    end else if (hdr_load && hdr.count != '0) begin
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    bulk_ok_q <= 1'b0;
                    if (desync_hit)    state_q <= ST_HUNT;
                    else if (cnt_last) state_q <= ST_HDR;
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R1: sync word seen while hunting gives synced next cycle
    p_sync_enter_r1: assert property (@(posedge clk) disable iff (rst)
        !synced && in_valid && in_word == SYNC_WORD |=> synced);
    // R1: nothing written while unsynchronized
    p_quiet_hunt_r1: assert property (@(posedge clk) disable iff (rst)
        !synced |-> !wr_valid && !hdr_err);
    // R8: an error word never also writes
    p_err_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> !wr_valid);
    // R7: the desync write drops synchronization
    p_desync_r7: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_addr == CMD_A && wr_data == DESYNC |=> !synced);
    // R6: payload count falls by one per data word
    p_count_dec_r6: assert property (@(posedge clk) disable iff (rst)
        in_data && !desync_hit && cnt > CNT_W'(1) |=> cnt == $past(cnt) - CNT_W'(1));
    // R10: idle cycles leave the state alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state_q) && $stable(addr_q));
endmodule

// File: tb/cfg_packet_parser_tb.sv
module cfg_packet_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        hdr_err;
    logic        synced;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference: 0 hunting, 1 header, 2 payload
    int          m_state = 0;
    longint      m_cnt = 0;
    logic [4:0]  m_addr = '0;
    bit          m_bulk = 0;

    always #5 clk = ~clk;

    cfg_packet_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .hdr_err(hdr_err), .synced(synced)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic [31:0] w, input string req);
        logic e_wv, e_err, e_sync;
        logic [4:0] e_a;
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        #1;
        e_sync = (m_state != 0);
        e_wv = 0; e_err = 0; e_a = m_addr;
        if (v) begin
            if (m_state == 0) begin
                if (w == 32'hAA995566) m_state = 1;
            end else if (m_state == 2) begin
                e_wv = 1;
                m_bulk = 0;
                if (m_addr == 5'd4 && w == 32'd13) begin
                    m_state = 0; m_cnt = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_state = 1;
                end
            end else begin
                if (w == 32'h20000000) begin
                    m_bulk = 0;
                end else if (w[31:29] == 3'b001 && w[28:27] == 2'b10) begin
                    m_addr = w[17:13];
                    m_cnt  = w[10:0];
                    m_bulk = (m_cnt == 0);
                    if (m_cnt != 0) m_state = 2;
                end else if (w[31:29] == 3'b010 && m_bulk) begin
                    m_cnt  = w[26:0];
                    m_bulk = 0;
                    if (m_cnt != 0) m_state = 2;
                end else begin
                    e_err = 1; m_bulk = 0;
                end
            end
        end
        chk(req, "wr_valid", 32'(wr_valid), 32'(e_wv));
        chk(req, "hdr_err",  32'(hdr_err),  32'(e_err));
        chk(req, "synced",   32'(synced),   32'(e_sync));
        if (e_wv) begin
            chk(req, "wr_addr", 32'(wr_addr), 32'(e_a));
            chk(req, "wr_data", wr_data, w);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_state = 0; m_cnt = 0; m_addr = '0; m_bulk = 0;
        #1;
        // R11: reset state
        chk("R11", "synced after reset", 32'(synced), 32'd0);
        chk("R11", "wr_valid after reset", 32'(wr_valid), 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: pads, width probes and headers before sync are dropped
        push(1, 32'hFFFFFFFF, "R1");
        push(1, 32'h000000BB, "R1");
        push(1, 32'h11220044, "R1");
        push(1, 32'h30008001, "R1");
        push(1, 32'h0000000D, "R1");
        push(0, 32'hAA995566, "R10");
        push(1, 32'hAA995566, "R1");
        // R2: no-operations
        push(1, 32'h20000000, "R2");
        push(1, 32'h20000000, "R2");
        // R3: single-word writes
        push(1, 32'h30022001, "R3");
        push(1, 32'h12345678, "R3");
        push(1, 32'h30008001, "R3");
        push(1, 32'h00000007, "R3");
        // R6: three-word payload that looks like control words, with a gap (R10)
        push(1, 32'h30026003, "R3");
        push(1, 32'hAA995566, "R6");
        push(0, 32'h30008001, "R10");
        push(1, 32'h30008001, "R6");
        push(1, 32'h20000000, "R6");
        // R4 and R5: zero-count short then bulk of 5
        push(1, 32'h30004000, "R4");
        push(1, 32'h50000005, "R5");
        for (int i = 0; i < 5; i++) push(1, 32'hC0DE0000 + 32'(i), "R5");
        // R4: zero-count with no bulk, then a normal header
        push(1, 32'h30010000, "R4");
        push(1, 32'h30002001, "R4");
        push(1, 32'h0000ABCD, "R4");
        // R9: bulk without pairing, and pairing broken by a NOP
        push(1, 32'h50000002, "R9");
        push(1, 32'h20000000, "R9");
        push(1, 32'h30004000, "R9");
        push(1, 32'h20000000, "R9");
        push(1, 32'h50000002, "R9");
        // R5: bulk with zero count stays in header state
        push(1, 32'h30004000, "R5");
        push(1, 32'h50000000, "R5");
        push(1, 32'h30002001, "R5");
        push(1, 32'h00000001, "R5");
        // R8: bad type and bad opcode
        push(1, 32'hFFFFFFFF, "R8");
        push(1, 32'h28000001, "R8");
        push(1, 32'h00000000, "R8");
        push(1, 32'hAA995566, "R8");
        push(1, 32'h30002001, "R8");
        push(1, 32'h00000002, "R8");
        // R7: desync then headers ignored until resync
        push(1, 32'h30008001, "R7");
        push(1, 32'h0000000D, "R7");
        push(1, 32'h30008001, "R7");
        push(1, 32'h00000005, "R7");
        push(1, 32'hAA995566, "R7");
        push(1, 32'h30002001, "R7");
        push(1, 32'h00000003, "R7");
        // R7: desync with words left in the packet
        push(1, 32'h30008003, "R7");
        push(1, 32'h0000000D, "R7");
        push(1, 32'hFFFFFFFF, "R7");
        push(1, 32'hAA995566, "R7");
        push(1, 32'h30008002, "R7");
        push(1, 32'h00000001, "R7");
        // R11: reset in the middle of a payload
        do_reset();
        push(1, 32'h00000009, "R11");
        push(1, 32'hAA995566, "R11");
        push(1, 32'h30002001, "R11");
        push(1, 32'h00000004, "R11");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule